// File: doc/BRIEF.md
# Peripheral Clock-Enable and Reset Sequencer

This block turns one peripheral on and off in a safe order. On an enable request it first checks whether the peripheral is already running. It counts as running only when its clock is on and it is not held in reset. If it is running, the request finishes at once and nothing changes. Otherwise the sequencer asserts the peripheral reset and waits a short hold time. It then switches the clock on, waits a much longer settle time, and releases the reset.

A peripheral built without a reset line gets its clock switched on directly. There is no wait and no reset activity. A disable request switches the clock off and leaves the reset output where it is. Both waits are given in microseconds and turned into cycle counts from a clock-frequency parameter, so a bench can shorten them by passing a small frequency.

The state machine has three states:
- `ST_IDLE` waits for a request. It takes transition `EV_ALREADY` (finish, no change), `EV_BEGIN_RST` (go to `ST_HOLD`), `EV_CLK_ONLY` (clock on, no reset line) or `EV_CLK_OFF` (disable).
- `ST_HOLD` counts the hold time, then takes `EV_CLK_ON` to `ST_SETTLE`.
- `ST_SETTLE` counts the settle time, then takes `EV_RELEASE` back to `ST_IDLE`.

Top module: `periph_enable_seq`

## Requirements
- R1: After reset, `clk_en_o`=0, `busy_o`=0 and `done_o`=0. `periph_rst_o`=1 when `HAS_RESET`=1, and 0 when `HAS_RESET`=0.
- R2: In idle, an enable request on a disabled peripheral with a reset line sets `periph_rst_o`=1 and `busy_o`=1 at the next clock edge.
- R3: `clk_en_o` rises exactly PRE cycles after the edge that asserted the reset, and the reset stays asserted meanwhile. PRE = max(1, CLK_FREQ_HZ*HOLD_US/1e6), with HOLD_US default 100.
- R4: `periph_rst_o` falls exactly SETTLE cycles after the edge that enabled the clock. SETTLE = max(1, CLK_FREQ_HZ*SETTLE_US/1e6), with SETTLE_US default 10000. `done_o` is 1 for exactly that one cycle, and `busy_o` returns to 0 in the same cycle.
- R5: An enable request while `clk_status_i`=1 and `rst_status_i`=0 gives `done_o`=1 for one cycle at the next edge. `busy_o` stays 0 and both outputs are unchanged.
- R6: While `rst_status_i`=1 the peripheral counts as disabled even if `clk_status_i`=1, so an enable request starts the full sequence.
- R7: With `HAS_RESET`=0, an enable request on a disabled peripheral sets `clk_en_o`=1 and `done_o`=1 at the next edge. `periph_rst_o` stays 0 and `busy_o` stays 0.
- R8: A disable request in idle sets `clk_en_o`=0 and `done_o`=1 at the next edge, and leaves `periph_rst_o` unchanged.
- R9: Enable and disable requests that arrive while `busy_o`=1 are ignored.
- R10: If enable and disable requests arrive in the same idle cycle, the enable request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en_req_i | input | 1 | Enable request strobe |
| dis_req_i | input | 1 | Disable request strobe |
| rst_status_i | input | 1 | Peripheral currently held in reset |
| clk_status_i | input | 1 | Peripheral clock currently running |
| clk_en_o | output | 1 | Peripheral clock enable |
| periph_rst_o | output | 1 | Peripheral reset, active high |
| busy_o | output | 1 | Timed sequence in progress |
| done_o | output | 1 | One-cycle pulse at the end of each request |

## Verification
The enable request is tried on four kinds of peripheral:
- A cold peripheral (clock off, reset held) exercises the full timed path and measures both waits.
- A running peripheral should finish at once, which separates the status decode from the sequence.
- A peripheral whose clock runs but whose reset is still held must still get the full sequence; this tells apart a check on the clock alone from one that also looks at reset.
- A peripheral with no reset line separates the short path from the timed one.

Enable and disable strobes that land in the hold and settle windows, and a simultaneous enable and disable, show that requests are ignored while busy and that enable wins when both arrive together.

// File: rtl/periph_enable_seq_pkg.sv
package periph_enable_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HOLD,
        ST_SETTLE
    } seq_state_e;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_ALREADY,
        EV_BEGIN_RST,
        EV_CLK_ONLY,
        EV_CLK_OFF,
        EV_CLK_ON,
        EV_RELEASE
    } seq_event_e;

    // Converts a duration in microseconds into clock cycles, never below one.
    function automatic longint us_to_cycles(longint hz, longint us);
        longint cyc;
        cyc = (hz * us) / 64'd1_000_000;
        return (cyc < 1) ? 64'd1 : cyc;
    endfunction

endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [W-1:0] len_i,
    output logic         last_o
);
    logic [W-1:0] remain_q;
    logic         run_q;

    assign last_o = run_q && (remain_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain_q <= '0;
            run_q    <= 1'b0;
        end else if (start_i) begin
            remain_q <= len_i - W'(1);
            run_q    <= 1'b1;
        end else if (last_o) begin
            run_q    <= 1'b0;
        end else if (run_q) begin
            remain_q <= remain_q - W'(1);
        end
    end

    // R3/R4: an active count steps down by one each cycle unless restarted
    a_r3_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && remain_q != '0 && !start_i) |=> (remain_q == $past(remain_q) - W'(1)));

endmodule

// File: rtl/periph_enable_seq.sv
module periph_enable_seq
    import periph_enable_seq_pkg::*;
#(
    parameter longint CLK_FREQ_HZ = 200_000_000,
    parameter longint HOLD_US     = 100,
    parameter longint SETTLE_US   = 10_000,
    parameter bit     HAS_RESET   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_req_i,
    input  logic dis_req_i,
    input  logic rst_status_i,
    input  logic clk_status_i,
    output logic clk_en_o,
    output logic periph_rst_o,
    output logic busy_o,
    output logic done_o
);
    localparam longint PRE_CYC    = us_to_cycles(CLK_FREQ_HZ, HOLD_US);
    localparam longint SETTLE_CYC = us_to_cycles(CLK_FREQ_HZ, SETTLE_US);
    localparam longint MAX_CYC    = (PRE_CYC > SETTLE_CYC) ? PRE_CYC : SETTLE_CYC;
    localparam int     CNT_W      = $clog2(MAX_CYC + 1);
    localparam logic [CNT_W-1:0] PRE_LEN    = PRE_CYC[CNT_W-1:0];
    localparam logic [CNT_W-1:0] SETTLE_LEN = SETTLE_CYC[CNT_W-1:0];

    seq_state_e       state_q, state_d;
    seq_event_e       ev;
    logic             t_start, t_last;
    logic [CNT_W-1:0] t_len;
    logic             is_enabled;
    logic             clk_en_q, rst_q, done_q;

    // A peripheral held in reset never counts as enabled.
    assign is_enabled = clk_status_i && (!HAS_RESET || !rst_status_i);

    seq_wait_timer #(.W(CNT_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (t_start),
        .len_i   (t_len),
        .last_o  (t_last)
    );

    // Next state and transition decode
    always_comb begin
        state_d = state_q;
        ev      = EV_NONE;
        t_start = 1'b0;
        t_len   = PRE_LEN;
        unique case (state_q)
            ST_IDLE: begin
                if (en_req_i) begin
                    if (is_enabled) begin
                        ev = EV_ALREADY;
                    end else if (HAS_RESET) begin
                        ev      = EV_BEGIN_RST;
                        state_d = ST_HOLD;
                        t_start = 1'b1;
                        t_len   = PRE_LEN;
                    end else begin
                        ev = EV_CLK_ONLY;
                    end
                end else if (dis_req_i) begin
                    ev = EV_CLK_OFF;
                end
            end
            ST_HOLD: begin
                if (t_last) begin
                    ev      = EV_CLK_ON;
                    state_d = ST_SETTLE;
                    t_start = 1'b1;
                    t_len   = SETTLE_LEN;
                end
            end
            ST_SETTLE: begin
                if (t_last) begin
                    ev      = EV_RELEASE;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output registers driven by the taken transition
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en_q <= 1'b0;
            rst_q    <= HAS_RESET;
            done_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (ev)
                EV_ALREADY:   done_q <= 1'b1;
                EV_BEGIN_RST: rst_q  <= 1'b1;
                EV_CLK_ONLY: begin
                    clk_en_q <= 1'b1;
                    done_q   <= 1'b1;
                end
                EV_CLK_OFF: begin
                    clk_en_q <= 1'b0;
                    done_q   <= 1'b1;
                end
                EV_CLK_ON:    clk_en_q <= 1'b1;
                EV_RELEASE: begin
                    rst_q  <= 1'b0;
                    done_q <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign clk_en_o     = clk_en_q;
    assign periph_rst_o = rst_q;
    assign busy_o       = (state_q != ST_IDLE);
    assign done_o       = done_q;

    // R3: with a reset line, the clock only turns on while reset is held
    a_r3_clk_under_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_RESET && $rose(clk_en_o)) |-> periph_rst_o);

    // R4: reset release comes with the clock running and the done pulse
    a_r4_release_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(periph_rst_o) |-> (clk_en_o && done_o));

    // R8: stopping the clock leaves reset alone and reports done
    a_r8_off_keeps_rst: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en_o) |-> ($stable(periph_rst_o) && done_o));

    // R9: the clock never stops as a result of a request taken while busy
    a_r9_no_off_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_en_o) |-> !$past(busy_o));

endmodule

// File: tb/periph_enable_seq_tb.sv
`timescale 1ns/1ps
module periph_enable_seq_tb;
    localparam longint FREQ    = 100_000;
    localparam int     EXP_PRE = 10;    // 100000*100/1e6
    localparam int     EXP_SET = 1000;  // 100000*10000/1e6

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic en = 0, dis = 0, ovr = 0, ovr_rst = 0, ovr_clk = 0;
    logic clk_en, periph_rst, busy, done;
    logic stat_rst, stat_clk;
    assign stat_rst = ovr ? ovr_rst : periph_rst;
    assign stat_clk = ovr ? ovr_clk : clk_en;

    logic en2 = 0, dis2 = 0;
    logic clk_en2, periph_rst2, busy2, done2;

    periph_enable_seq #(.CLK_FREQ_HZ(FREQ), .HAS_RESET(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .en_req_i(en), .dis_req_i(dis),
        .rst_status_i(stat_rst), .clk_status_i(stat_clk),
        .clk_en_o(clk_en), .periph_rst_o(periph_rst), .busy_o(busy), .done_o(done));

    periph_enable_seq #(.CLK_FREQ_HZ(FREQ), .HAS_RESET(1'b0)) u_dut_nr (
        .clk(clk), .rst_n(rst_n), .en_req_i(en2), .dis_req_i(dis2),
        .rst_status_i(periph_rst2), .clk_status_i(clk_en2),
        .clk_en_o(clk_en2), .periph_rst_o(periph_rst2), .busy_o(busy2), .done_o(done2));

    int checks = 0, fails = 0, cyc = 0;
    bit finished = 0;

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference model of the reset-line variant
    int m_phase = 0, m_tmr = 0;
    bit m_clk = 0, m_rst = 1, m_done = 0;
    always @(posedge clk) begin
        bit s_rst, s_clk;
        if (!rst_n) begin
            m_clk = 0; m_rst = 1; m_done = 0; m_phase = 0; m_tmr = 0;
        end else begin
            s_rst = ovr ? ovr_rst : m_rst;
            s_clk = ovr ? ovr_clk : m_clk;
            m_done = 0;
            if (m_phase == 0) begin
                if (en) begin
                    if (s_clk && !s_rst) m_done = 1;
                    else begin m_rst = 1; m_phase = 1; m_tmr = EXP_PRE; end
                end else if (dis) begin
                    m_clk = 0; m_done = 1;
                end
            end else if (m_phase == 1) begin
                m_tmr--;
                if (m_tmr == 0) begin m_clk = 1; m_phase = 2; m_tmr = EXP_SET; end
            end else begin
                m_tmr--;
                if (m_tmr == 0) begin m_rst = 0; m_phase = 0; m_done = 1; end
            end
        end
    end

    // Compare against the model on every cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R3", "model clk_en", clk_en, m_clk);
            chk("R2", "model periph_rst", periph_rst, m_rst);
            chk("R9", "model busy", busy, m_phase != 0);
            chk("R4", "model done", done, m_done);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 60000 && !finished) begin
            finished = 1;
            fails++;
            $display("FAIL watchdog actual=%0d expected=<60000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1", "reset clk_en", clk_en, 0);
        chk("R1", "reset periph_rst", periph_rst, 1);
        chk("R1", "reset busy", busy, 0);
        chk("R1", "reset done", done, 0);
        chk("R1", "no-line reset periph_rst", periph_rst2, 0);
        chk("R1", "no-line reset clk_en", clk_en2, 0);

        // Cold enable: full sequence, with a disable landing during settle
        en = 1; @(negedge clk); en = 0;
        chk("R2", "reset asserted", periph_rst, 1);
        chk("R2", "busy raised", busy, 1);
        n = 0;
        while (!clk_en && n < 5000) begin @(negedge clk); n++; end
        chk("R3", "hold cycles", n, EXP_PRE);
        chk("R3", "reset held at clock on", periph_rst, 1);
        n = 0;
        while (periph_rst && n < 5000) begin
            dis = (n == 5);
            @(negedge clk); n++;
        end
        dis = 0;
        chk("R4", "settle cycles", n, EXP_SET);
        chk("R4", "done at release", done, 1);
        chk("R4", "busy dropped", busy, 0);
        chk("R9", "disable in settle ignored", clk_en, 1);
        @(negedge clk);
        chk("R4", "done single cycle", done, 0);

        // Already enabled
        en = 1; @(negedge clk); en = 0;
        chk("R5", "done at once", done, 1);
        chk("R5", "no busy", busy, 0);
        chk("R5", "clock unchanged", clk_en, 1);
        chk("R5", "reset unchanged", periph_rst, 0);

        // Disable
        dis = 1; @(negedge clk); dis = 0;
        chk("R8", "clock off", clk_en, 0);
        chk("R8", "reset untouched", periph_rst, 0);
        chk("R8", "done", done, 1);

        // Simultaneous requests, then requests during hold
        en = 1; dis = 1; @(negedge clk); en = 0; dis = 0;
        chk("R10", "enable wins busy", busy, 1);
        chk("R10", "enable wins reset", periph_rst, 1);
        repeat (2) @(negedge clk);
        en = 1; dis = 1; @(negedge clk); en = 0; dis = 0;
        chk("R9", "still in sequence", busy, 1);
        n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        chk("R9", "ran to completion clk", clk_en, 1);
        chk("R9", "ran to completion rst", periph_rst, 0);
        chk("R9", "single sequence length", n, EXP_PRE + EXP_SET - 3);

        // Clock running but reset held: must be treated as disabled
        ovr = 1; ovr_clk = 1; ovr_rst = 1;
        en = 1; @(negedge clk); en = 0;
        chk("R6", "sequence started", busy, 1);
        chk("R6", "done not immediate", done, 0);
        ovr = 0;
        n = 0;
        while (busy && n < 5000) begin @(negedge clk); n++; end
        chk("R6", "finished clk", clk_en, 1);
        chk("R6", "finished rst", periph_rst, 0);

        // No reset line
        en2 = 1; @(negedge clk); en2 = 0;
        chk("R7", "clock on", clk_en2, 1);
        chk("R7", "done", done2, 1);
        chk("R7", "no busy", busy2, 0);
        chk("R7", "reset stays low", periph_rst2, 0);
        dis2 = 1; @(negedge clk); dis2 = 0;
        chk("R8", "no-line clock off", clk_en2, 0);
        chk("R8", "no-line reset low", periph_rst2, 0);
        chk("R8", "no-line done", done2, 1);

        repeat (3) @(negedge clk);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule